// File: doc/BRIEF.md
# Counter-Driven Flowchart Sequencer

This block is a control sequencer whose state is held in a loadable binary counter rather than in an encoded transition table. Each state tests exactly one single-bit condition input: the counter value selects which bit of the condition vector is examined, and that bit is presented as the outcome Y. When the outcome is true, a YES function line for the current state is raised and the counter steps to the numerically next state. When it is false, a NO function line for the current state is raised and the counter stays where it is.

Out-of-order flow (loops, branches) is obtained through jumps. A compile-time table gives, for every state and each outcome, a jump-enable bit and a destination state. When the active function line has its jump bit set, an active-low load is asserted and the counter takes the destination instead of stepping or holding. The function lines are Mealy outputs, depending on both the state and the live condition input, and are used by surrounding logic as single-cycle command strobes.

Top module: `flow_sequencer`

## Requirements
- R1: `cond_y` equals bit `state` of `cond` (state i tests condition bit i).
- R2: When `cond_y` is 1 and the active YES line has no jump enabled, the next state is `state + 1`, with the last state (7 by default) wrapping to 0.
- R3: When `cond_y` is 0 and the active NO line has no jump enabled, the state is held.
- R4: Out of reset, with `cond_y` high, `yes_strobe` has only bit `state` set and `no_strobe` is all zero; with `cond_y` low, `no_strobe` has only bit `state` set and `yes_strobe` is all zero.
- R5: Out of reset, exactly one bit across `yes_strobe` and `no_strobe` together is set in every cycle.
- R6: When the active function line has its jump-enable bit set (bit i of `YES_JMP_EN` or `NO_JMP_EN` for state i), the next state is that function's destination field, bits `[i*STATE_W +: STATE_W]` of `YES_JMP_DST` or `NO_JMP_DST`; the jump takes priority over stepping and holding.
- R7: A jump enabled for one outcome of a state has no effect when the other outcome occurs in that state; the default step or hold is taken.
- R8: While `rst_n` is 0, both strobe vectors are all zero, and a rising clock edge with `rst_n` at 0 sets the state to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cond | input | NUM_STATES | Condition bits, one tested per state |
| yes_strobe | output | NUM_STATES | YES function lines, one per state |
| no_strobe | output | NUM_STATES | NO function lines, one per state |
| cond_y | output | 1 | Outcome of the condition tested in the current state |
| state | output | STATE_W | Current counter value |

## Verification
A jump and the default step are both selected by a YES outcome, so in one cycle the counter has to choose between load and increment; likewise a jump on NO competes with hold. The bench builds a flowchart with a YES jump from state 5 back to 2 and a NO jump from state 3 forward to 6, drives the condition that makes the jumping function fire, and compares the next state with the destination rather than with the stepped or held value. It also visits state 3 with a true condition to confirm that the NO jump does not leak into the YES path.

// File: rtl/seq_pkg.sv
// Shared constants for the flowchart sequencer.
// Assumes the condition vector width equals the state count.
package seq_pkg;
    localparam int SEQ_STATE_W_DEF = 3;
    localparam int SEQ_STATES_DEF  = 1 << SEQ_STATE_W_DEF;
endpackage

// File: rtl/cond_select.sv
// Condition multiplexer: picks the condition bit indexed by the state
// and returns it as the outcome together with its inverse.
// Assumes COND_W equals 2**SEL_W.
module cond_select #(
    parameter int SEL_W  = 3,
    parameter int COND_W = 1 << SEL_W
) (
    input  logic [COND_W-1:0] cond,
    input  logic [SEL_W-1:0]  sel,
    output logic              y,
    output logic              wn
);
    // Select the tested bit and form its complement.
    always_comb begin
        y  = cond[sel];
        wn = ~y;
    end
endmodule

// File: rtl/func_decoder.sv
// One-hot function decoder with an active-low enable: when enabled the
// output line numbered by sel is raised, otherwise all lines are low.
// Assumes N equals 2**SEL_W.
module func_decoder #(
    parameter int SEL_W = 3,
    parameter int N     = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic [SEL_W-1:0] sel,
    output logic [N-1:0]     lines
);
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_line
            // Raise line gi when enabled and selected.
            assign lines[gi] = ~en_n && (sel == SEL_W'(gi));
        end
    endgenerate

    // R4: a disabled decoder drives no line.
    assert_idle_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |-> (lines == '0));
    // R4: never more than one line.
    assert_onehot_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lines));
endmodule

// File: rtl/jump_logic.sv
// Jump decode: from the active YES/NO function lines and the compile-time
// jump table, forms the active-low counter load and the destination.
// Assumes at most one function line is high at a time.
module jump_logic #(
    parameter int                       STATE_W     = 3,
    parameter int                       N           = 1 << STATE_W,
    parameter logic [N-1:0]             YES_JMP_EN  = '0,
    parameter logic [N*STATE_W-1:0]     YES_JMP_DST = '0,
    parameter logic [N-1:0]             NO_JMP_EN   = '0,
    parameter logic [N*STATE_W-1:0]     NO_JMP_DST  = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       yes_lines,
    input  logic [N-1:0]       no_lines,
    output logic               load_n,
    output logic [STATE_W-1:0] dst
);
    logic [N-1:0]       yes_hit;
    logic [N-1:0]       no_hit;
    logic [STATE_W-1:0] yes_term [N];
    logic [STATE_W-1:0] no_term  [N];

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_func
            // Per-function jump request and gated destination.
            assign yes_hit[gi]  = yes_lines[gi] & YES_JMP_EN[gi];
            assign no_hit[gi]   = no_lines[gi]  & NO_JMP_EN[gi];
            assign yes_term[gi] = yes_hit[gi] ? YES_JMP_DST[gi*STATE_W +: STATE_W] : '0;
            assign no_term[gi]  = no_hit[gi]  ? NO_JMP_DST[gi*STATE_W +: STATE_W]  : '0;
        end
    endgenerate

    // Merge all gated destinations and form the active-low load.
    always_comb begin
        dst = '0;
        for (int i = 0; i < N; i++) begin
            dst = dst | yes_term[i] | no_term[i];
        end
        load_n = ~(|yes_hit | |no_hit);
    end

    // R6: a load is only requested while some function line is active.
    assert_load_needs_func_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> (|{yes_lines, no_lines}));
endmodule

// File: rtl/state_counter.sv
// Loadable state counter: synchronous active-low reset to 0, then load
// (active-low) over count-enable over hold. Counting wraps naturally.
module state_counter #(
    parameter int STATE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_n,
    input  logic [STATE_W-1:0] load_val,
    input  logic               cnt_en,
    output logic [STATE_W-1:0] count
);
    // Update the state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!load_n) begin
            count <= load_val;
        end else if (cnt_en) begin
            count <= count + 1'b1;
        end
    end

    // R2: enabled count without load steps by one.
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en) |=> count == STATE_W'($past(count) + 1'b1));
    // R3: no enable and no load holds the value.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en) |=> $stable(count));
    // R6: a load lands the requested value.
    assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> count == $past(load_val));
    // R8: reset clears the state.
    assert_reset_R8: assert property (@(posedge clk)
        !rst_n |=> count == '0);
endmodule

// File: rtl/flow_sequencer.sv
// Flowchart sequencer top: the state counter selects one condition bit,
// the outcome steers a YES or a NO function decoder, and the jump table
// may redirect the counter from the active function line.
// Assumes cond has one bit per state; strobes are combinational (Mealy).
module flow_sequencer
    import seq_pkg::*;
#(
    parameter int                        STATE_W     = SEQ_STATE_W_DEF,
    parameter int                        NUM_STATES  = 1 << STATE_W,
    parameter logic [NUM_STATES-1:0]         YES_JMP_EN  = '0,
    parameter logic [NUM_STATES*STATE_W-1:0] YES_JMP_DST = '0,
    parameter logic [NUM_STATES-1:0]         NO_JMP_EN   = '0,
    parameter logic [NUM_STATES*STATE_W-1:0] NO_JMP_DST  = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STATES-1:0] cond,
    output logic [NUM_STATES-1:0] yes_strobe,
    output logic [NUM_STATES-1:0] no_strobe,
    output logic                  cond_y,
    output logic [STATE_W-1:0]    state
);
    logic               wn;
    logic               yes_en_n;
    logic               no_en_n;
    logic               load_n;
    logic [STATE_W-1:0] jump_dst;

    cond_select #(.SEL_W(STATE_W), .COND_W(NUM_STATES)) u_mux (
        .cond (cond),
        .sel  (state),
        .y    (cond_y),
        .wn   (wn)
    );

    // Decoder enables: YES gated by the inverse outcome, NO by the outcome,
    // both forced off during reset.
    always_comb begin
        yes_en_n = wn | ~rst_n;
        no_en_n  = cond_y | ~rst_n;
    end

    func_decoder #(.SEL_W(STATE_W), .N(NUM_STATES)) u_yes_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .en_n  (yes_en_n),
        .sel   (state),
        .lines (yes_strobe)
    );

    func_decoder #(.SEL_W(STATE_W), .N(NUM_STATES)) u_no_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .en_n  (no_en_n),
        .sel   (state),
        .lines (no_strobe)
    );

    jump_logic #(
        .STATE_W     (STATE_W),
        .N           (NUM_STATES),
        .YES_JMP_EN  (YES_JMP_EN),
        .YES_JMP_DST (YES_JMP_DST),
        .NO_JMP_EN   (NO_JMP_EN),
        .NO_JMP_DST  (NO_JMP_DST)
    ) u_jump (
        .clk       (clk),
        .rst_n     (rst_n),
        .yes_lines (yes_strobe),
        .no_lines  (no_strobe),
        .load_n    (load_n),
        .dst       (jump_dst)
    );

    state_counter #(.STATE_W(STATE_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .load_val (jump_dst),
        .cnt_en   (cond_y),
        .count    (state)
    );

    // R5: exactly one function line across both decoders.
    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({yes_strobe, no_strobe}) == 1);
    // R1: the outcome agrees with the YES line of the current state.
    assert_outcome_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cond_y == yes_strobe[state]);
    // R8: no strobe while in reset.
    assert_quiet_in_reset_R8: assert property (@(posedge clk)
        !rst_n |-> ({yes_strobe, no_strobe} == '0));
endmodule

// File: tb/flow_sequencer_tb.sv
module flow_sequencer_tb;
    localparam int SW = 3;
    localparam int NS = 1 << SW;
    // Flowchart: YES in state 5 jumps to 2, NO in state 3 jumps to 6.
    localparam logic [NS-1:0]    T_YES_EN  = 8'b0010_0000;
    localparam logic [NS*SW-1:0] T_YES_DST = 24'd2 << (5*SW);
    localparam logic [NS-1:0]    T_NO_EN   = 8'b0000_1000;
    localparam logic [NS*SW-1:0] T_NO_DST  = 24'd6 << (3*SW);

    // Each entry: {cond[7:0], expected current state[2:0], expected next state[2:0]}
    localparam int NSTEP = 15;
    localparam logic [13:0] STEPS [NSTEP] = '{
        {8'hFF, 3'd0, 3'd1},  // R2 step
        {8'h00, 3'd1, 3'd1},  // R3 hold
        {8'h02, 3'd1, 3'd2},  // R1 only bit 1 matters
        {8'h04, 3'd2, 3'd3},
        {8'h00, 3'd3, 3'd6},  // R6 NO jump
        {8'hBF, 3'd6, 3'd6},  // R3 hold, bit 6 low
        {8'h40, 3'd6, 3'd7},
        {8'h80, 3'd7, 3'd0},  // R2 wrap
        {8'h01, 3'd0, 3'd1},
        {8'hFF, 3'd1, 3'd2},
        {8'hFF, 3'd2, 3'd3},
        {8'hFF, 3'd3, 3'd4},  // R7 NO jump ignored on YES
        {8'hFF, 3'd4, 3'd5},
        {8'h20, 3'd5, 3'd2},  // R6 YES jump loops back
        {8'hDF, 3'd2, 3'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] cond = '0;
    logic [NS-1:0] yes_strobe;
    logic [NS-1:0] no_strobe;
    logic          cond_y;
    logic [SW-1:0] state;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    flow_sequencer #(
        .STATE_W(SW), .YES_JMP_EN(T_YES_EN), .YES_JMP_DST(T_YES_DST),
        .NO_JMP_EN(T_NO_EN), .NO_JMP_DST(T_NO_DST)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cond(cond), .yes_strobe(yes_strobe),
        .no_strobe(no_strobe), .cond_y(cond_y), .state(state)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Check outputs for the present state and condition.
    task automatic check_comb(input logic [SW-1:0] st, input logic [NS-1:0] c);
        logic y;
        y = c[st];
        check("R1 state", 32'(state), 32'(st));
        check("R1 cond_y", 32'(cond_y), 32'(y));
        check("R4 yes_strobe", 32'(yes_strobe), y ? 32'(1) << st : 32'd0);
        check("R4 no_strobe", 32'(no_strobe), y ? 32'd0 : 32'(1) << st);
        check("R5 one strobe", 32'($countones({yes_strobe, no_strobe})), 32'd1);
    endtask

    initial begin
        #40000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R8: reset state and quiet strobes.
        cond = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 state in reset", 32'(state), 32'd0);
        check("R8 strobes in reset", 32'({yes_strobe, no_strobe}), 32'd0);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < NSTEP; i++) begin
            cond = STEPS[i][13:6];
            #1;
            check_comb(STEPS[i][5:3], STEPS[i][13:6]);
            @(negedge clk);
            check("R2/R3/R6/R7 next state", 32'(state), 32'(STEPS[i][2:0]));
        end

        // R8: reset taken from a nonzero state while a YES jump would fire.
        cond = '1;
        for (int k = 0; k < 2; k++) @(negedge clk);   // 3 -> 4 -> 5
        check("R2 reach state 5", 32'(state), 32'd5);
        rst_n = 1'b0;
        #1;
        check("R8 strobes off", 32'({yes_strobe, no_strobe}), 32'd0);
        @(negedge clk);
        check("R8 reset overrides jump", 32'(state), 32'd0);
        rst_n = 1'b1;

        // R3: long hold on a false condition.
        cond = 8'hFE;
        for (int k = 0; k < 4; k++) @(negedge clk);
        check("R3 long hold", 32'(state), 32'd0);
        check("R4 no line during hold", 32'(no_strobe), 32'd1);

        finish_run();
    end
endmodule